// File: doc/BRIEF.md
# DMA Bridge Event Interrupt Register

This block is a single 32-bit control and status register for a DMA bridge. Ten transfer events come in as one-cycle pulses: USB transfer done, USB address error, and for each of two audio channels a play all-done, a play half-done, a record all-done and a record half-done. Each event sets a sticky status bit. A per-event enable bit decides whether that status bit may raise an interrupt.

The enabled, set status bits are merged by kind onto three level-sensitive interrupt lines:

- an error line;
- a completion line, which the USB completion shares with the audio completions;
- a half-completion line.

Software reads the register to see which events occurred. It acknowledges an event by writing 0 to that status bit, and masks an event by writing 0 to its enable bit. Status bits written with 1 keep their value, so a read-modify-write of the whole register cannot lose or invent an event.

Top module: `dbrg_evt_irq_reg`

## Requirements
- R1: After reset every register bit reads 0 and all three interrupt lines are low.
- R2: Event n sets its status bit on the clock edge where its pulse is sampled. The bit is at position n for n = 0 (USB done) and n = 1 (USB address error), and at position n+14 for audio events n = 2..9. Audio events are ordered: channel 0 play all-done, play half-done, record all-done, record half-done, then the same four for channel 1.
- R3: The enable bit of event n is at position n+8 for n = 0..1 and at position n+22 for n = 2..9. A register write loads every enable bit from the write data, and the enable bits read back.
- R4: A write with 0 in a status bit position clears that status bit. A write with 1 there leaves the bit unchanged.
- R5: A status bit sets on its event even while its enable bit is 0.
- R6: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R7: Interrupt line 0 carries only event 1, the USB address error.
- R8: Interrupt line 1 is the OR of events 0, 2, 4, 6 and 8, each taken only when its status bit and enable bit are both 1.
- R9: Interrupt line 2 is the OR of events 3, 5, 7 and 9, each taken only when its status bit and enable bit are both 1.
- R10: Each interrupt line is registered. It reflects the register contents as they stood before the previous clock edge, so a line rises one cycle after its status bit and enable bit are both 1, and falls one cycle after the last such pair clears.
- R11: Bits 15..10 and 7..2 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| evt_pulse | input | 10 | Event pulses, bit n is event n |
| irq | output | 3 | Interrupt lines: 0 error, 1 completion, 2 half-completion |

## Verification
The hardest situation to reach from the ports is a collision: an event pulse and an acknowledging write land on the same status bit in the same cycle, and a read-modify-write must still preserve events that arrive in between. The bench drives each event together with a write of zero to every bit. It also runs a long stretch of pseudo-random pulses and writes in which collisions happen often. A bench-side model of the register image predicts both the readback and the one-cycle-late interrupt lines on every cycle of that stretch.

// File: rtl/dbrg_pkg.sv
package dbrg_pkg;
  localparam int NUM_EVT  = 10;
  localparam int NUM_IRQ  = 3;
  localparam int REG_W    = 32;
  localparam int USB_EVTS = 2;

  localparam int GRP_ERR  = 0;
  localparam int GRP_DONE = 1;
  localparam int GRP_HALF = 2;

  // status bit position of event n
  function automatic int sts_pos(input int n);
    return (n < USB_EVTS) ? n : n + 14;
  endfunction

  // enable bit position of event n
  function automatic int ena_pos(input int n);
    return (n < USB_EVTS) ? n + 8 : n + 22;
  endfunction

  // interrupt line that event n feeds
  function automatic int evt_group(input int n);
    if (n == 1)              return GRP_ERR;
    else if ((n % 2) == 0)   return GRP_DONE;
    else                     return GRP_HALF;
  endfunction
endpackage

// File: rtl/dbrg_evt_cell.sv
module dbrg_evt_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic sts_wbit_i,
  input  logic ena_wbit_i,
  input  logic evt_i,
  output logic sts_o,
  output logic ena_o
);
  logic sts_q, ena_q;
  logic clr_req;

  assign clr_req = wr_i && !sts_wbit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      ena_q <= 1'b0;
    end else begin
      if (evt_i)        sts_q <= 1'b1;
      else if (clr_req) sts_q <= 1'b0;
      if (wr_i)         ena_q <= ena_wbit_i;
    end
  end

  assign sts_o = sts_q;
  assign ena_o = ena_q;

  // R2 / R5 / R6: an event always leaves the bit set
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> sts_q);
  // R4: status only falls after a clearing write
  a_r4_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_q) |-> $past(wr_i && !sts_wbit_i));
  // R4: status never rises without an event
  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(evt_i));
  // R3: enable follows written value
  a_r3_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (ena_q == $past(ena_wbit_i)));
  a_r3_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ena_q));
endmodule

// File: rtl/dbrg_irq_merge.sv
module dbrg_irq_merge
  import dbrg_pkg::*;
#(
  parameter int N_EVT = NUM_EVT,
  parameter int N_IRQ = NUM_IRQ
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] sts_i,
  input  logic [N_EVT-1:0] ena_i,
  output logic [N_IRQ-1:0] irq_o
);
  logic [N_EVT-1:0] pend;
  logic [N_IRQ-1:0] grp_any;
  logic [N_IRQ-1:0] irq_q;

  assign pend = sts_i & ena_i;

  always_comb begin
    grp_any = '0;
    for (int n = 0; n < N_EVT; n++) begin
      if (pend[n]) grp_any[evt_group(n)] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= grp_any;
  end

  assign irq_o = irq_q;

  // R10: each line lags its group by exactly one cycle
  a_r10_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == $past(grp_any));
  // R10: a line cannot be high without some enabled pending event last cycle
  a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_q) |-> $past(|pend));
endmodule

// File: rtl/dbrg_evt_irq_reg.sv
module dbrg_evt_irq_reg
  import dbrg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic [NUM_IRQ-1:0] irq
);
  logic [NUM_EVT-1:0] sts_vec;
  logic [NUM_EVT-1:0] ena_vec;
  logic [REG_W-1:0]   used_mask;
  logic               unused_wbits;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    dbrg_evt_cell cell_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (reg_wr),
      .sts_wbit_i (reg_wdata[sts_pos(g)]),
      .ena_wbit_i (reg_wdata[ena_pos(g)]),
      .evt_i      (evt_pulse[g]),
      .sts_o      (sts_vec[g]),
      .ena_o      (ena_vec[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    used_mask = '0;
    for (int n = 0; n < NUM_EVT; n++) begin
      reg_rdata[sts_pos(n)] = sts_vec[n];
      reg_rdata[ena_pos(n)] = ena_vec[n];
      used_mask[sts_pos(n)] = 1'b1;
      used_mask[ena_pos(n)] = 1'b1;
    end
  end

  assign unused_wbits = ^(reg_wdata & ~used_mask);

  dbrg_irq_merge #(.N_EVT(NUM_EVT), .N_IRQ(NUM_IRQ)) merge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .sts_i (sts_vec),
    .ena_i (ena_vec),
    .irq_o (irq)
  );

  // R11: reserved bits stay zero
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:10] == '0) && (reg_rdata[7:2] == '0));
  // R7: error line sourced only by the USB address error
  a_r7_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq[GRP_ERR] |-> $past(sts_vec[1] && ena_vec[1]));
  // R9: half line needs an odd audio event
  a_r9_half_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq[GRP_HALF] |-> $past(|(sts_vec & ena_vec & 10'b10_1010_1000)));
  // R8: completion line needs an even event
  a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq[GRP_DONE] |-> $past(|(sts_vec & ena_vec & 10'b01_0101_0101)));
endmodule

// File: tb/dbrg_evt_irq_reg_tb.sv
module dbrg_evt_irq_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [9:0]  evt_pulse = '0;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = '0;
  logic [2:0]  exp_irq = '0;

  localparam logic [31:0] STS_M = 32'h00FF_0003;
  localparam logic [31:0] ENA_M = 32'hFF00_0300;

  always #2 clk = ~clk;

  dbrg_evt_irq_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  function automatic logic [31:0] evt_image(input logic [9:0] e);
    logic [31:0] r = '0;
    for (int n = 0; n < 10; n++)
      if (e[n]) r = r | ((n < 2) ? (32'd1 << n) : (32'd1 << (16 + n - 2)));
    return r;
  endfunction

  function automatic logic [2:0] irq_of(input logic [31:0] r);
    logic [31:0] a;
    a = r & STS_M & (r >> 8);
    return {a[17] | a[19] | a[21] | a[23],
            a[0] | a[16] | a[18] | a[20] | a[22],
            a[1]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock with given inputs; checks readback and irq afterwards
  task automatic step(input string tag, input logic wr, input logic [31:0] wd,
                      input logic [9:0] ev);
    logic [31:0] nxt;
    reg_wr = wr; reg_wdata = wd; evt_pulse = ev;
    @(negedge clk);
    exp_irq = irq_of(model);
    nxt = wr ? ((model & STS_M & wd) | (wd & ENA_M)) : model;
    model = nxt | evt_image(ev);
    reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
    chk({tag, " rdata"}, reg_rdata, model);
    chk({tag, " irq"}, {29'd0, irq}, {29'd0, exp_irq});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rdata", reg_rdata, 32'd0);
    chk("R1 irq", {29'd0, irq}, 32'd0);

    // per-event sweep, enabled and masked
    for (int n = 0; n < 10; n++) begin
      for (int en = 0; en < 2; en++) begin
        logic [31:0] ebit;
        logic [31:0] sbit;
        int grp;
        ebit = (n < 2) ? (32'd1 << (n + 8)) : (32'd1 << (n + 22));
        sbit = (n < 2) ? (32'd1 << n) : (32'd1 << (n + 14));
        grp  = (n == 1) ? 0 : ((n % 2 == 0) ? 1 : 2);
        step("R3", 1'b1, en ? ebit : 32'd0, 10'd0);
        chk("R3 enable pos", reg_rdata & ENA_M, en ? ebit : 32'd0);
        step("R2", 1'b0, 32'd0, 10'd1 << n);
        chk("R2 status pos", reg_rdata & STS_M, sbit);
        chk("R10 irq not yet", {29'd0, irq}, 32'd0);
        step("R5", 1'b0, 32'd0, 10'd0);
        if (grp == 0) chk("R7 line", {31'd0, irq[0]}, en);
        if (grp == 1) chk("R8 line", {31'd0, irq[1]}, en);
        if (grp == 2) chk("R9 line", {31'd0, irq[2]}, en);
        chk("R5 status kept", reg_rdata & STS_M, sbit);
        step("R4 keep", 1'b1, reg_rdata, 10'd0);
        chk("R4 write one keeps", reg_rdata & STS_M, sbit);
        step("R4 clear", 1'b1, reg_rdata & ~sbit, 10'd0);
        chk("R4 cleared", reg_rdata & STS_M, 32'd0);
        step("R10 fall", 1'b0, 32'd0, 10'd0);
        chk("R10 irq dropped", {29'd0, irq}, 32'd0);
        // collision: event plus clear-all on same edge
        step("R6", 1'b1, 32'd0, 10'd1 << n);
        chk("R6 event wins", reg_rdata & STS_M, sbit);
        step("R6 clr", 1'b1, 32'd0, 10'd0);
      end
    end

    // reserved bits
    step("R11", 1'b1, 32'hFFFF_FFFF, 10'd0);
    chk("R11 reserved zero", reg_rdata & ~(STS_M | ENA_M), 32'd0);
    step("R11 all events", 1'b0, 32'd0, 10'h3FF);
    step("R11 idle", 1'b0, 32'd0, 10'd0);
    chk("R11 all lines", {29'd0, irq}, 32'd7);

    // pseudo-random stretch
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] wd;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wd = {lfsr, lfsr ^ 16'h5A3C};
      step("R10 random", lfsr[0] & lfsr[3], wd, lfsr[12:3] & {10{lfsr[1]}});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule